// File: doc/BRIEF.md
# Coherence Directory with Block Poisoning

This block keeps the coherence directory for a set of memory blocks in a shared-memory system. Each block has a directory entry holding its state (unowned, shared, exclusive, poisoned, or one of two transient poison-pending states), a vector of sharing nodes and an owner node. Nodes send read, write, writeback and invalidation-acknowledge messages. The directory answers each message with a grant, a negative acknowledgement (retry), a bus error or a completion code. When coherence requires it, the directory also issues invalidations to sharers or an intervention to the exclusive owner.

The directory also supports page migration by poisoning blocks. A poison command first pulls the latest copy back to memory. An exclusive owner is sent an intervention and must write the block back. Sharers are invalidated and must all acknowledge. Only then does the entry become poisoned, and a completion pulse is raised. From that point every read or write to the block is answered with a synchronous bus error. A requester uses that error as its cue to drop its own stale address translation, so no system-wide translation flush is needed. An unpoison command returns the block to the unowned state.

Requests arrive one per cycle. Every request gets exactly one response, registered, in the following cycle.

Top module: `dir_poison_ctrl`

## Requirements
- R1: After reset every entry is unowned with no sharers, all outputs are low or zero, and a first read of any block is granted exclusive.
- R2: A read (op 0) to an unowned block answers grant-exclusive (code 1) and records the requester as owner.
- R3: A read to a shared block answers grant-shared (code 0) and adds the requester to the sharers. A read to a block held exclusive by another node answers grant-shared, sends an intervention to the old owner, and leaves both nodes as sharers.
- R4: A write (op 1) to a shared block grants exclusive and raises invalidations for every other sharer. A write to a block held exclusive by another node sends an intervention to the old owner and moves ownership. Invalidation and intervention never appear in the same cycle.
- R5: A read or write by the node that already owns the block exclusive is granted exclusive again with no message to any node, because clean-exclusive copies may be dropped silently.
- R6: A writeback (op 2) from the exclusive owner answers done (code 4) and makes the block unowned. A writeback from any other node is NACKed (code 2) and changes nothing.
- R7: Poison (op 4) on an unowned block poisons it at once, answers done and pulses poison_done with the block number. Poison on an already poisoned block answers done with no pulse.
- R8: Poison on an exclusive block answers accept (code 5) and sends an intervention to the owner. The block becomes poisoned, with done and a poison_done pulse, only when the owner's writeback arrives.
- R9: Poison on a shared block answers accept and invalidates all sharers. Each invalidation-acknowledge (op 3) from a pending sharer answers done. The last one poisons the block and pulses poison_done. An acknowledge at any other time answers done and changes nothing.
- R10: While a poison is pending, read, write, poison and unpoison to that block are NACKed and leave its state unchanged. A writeback from a non-owner is also NACKed.
- R11: A read or write to a poisoned block answers bus error (code 3).
- R12: Unpoison (op 5) on a poisoned block answers done and makes it unowned with no sharers. Unpoison in any other state, and any op code 6 or 7, is NACKed.
- R13: Each request cycle yields exactly one response in the next cycle, addressed to the requesting node. Idle cycles yield none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | 0 read, 1 write, 2 writeback, 3 inval ack, 4 poison, 5 unpoison |
| req_node | input | NODE_W | Requesting node |
| req_blk | input | BLK_W | Addressed block |
| rsp_valid | output | 1 | Response present |
| rsp_node | output | NODE_W | Node the response goes to |
| rsp_code | output | 3 | 0 shared, 1 exclusive, 2 NACK, 3 bus error, 4 done, 5 accept |
| inv_valid | output | 1 | Invalidations issued |
| inv_mask | output | NNODE | Nodes to invalidate (zero when idle) |
| intv_valid | output | 1 | Intervention issued |
| intv_node | output | NODE_W | Owner receiving the intervention (zero when idle) |
| poison_done | output | 1 | A block has just become poisoned |
| poison_blk | output | BLK_W | That block (zero when idle) |

## Verification
A corrupted entry stays hidden until its block is addressed again. The next request to that block then shows the damage one cycle later: a wrong grant code, a missing or misdirected intervention or invalidation mask, or a bus error where data was due. Lost acknowledgement bits show up as a poison_done pulse that comes too early or never comes. A reference directory in the bench predicts every output field for every cycle, and the random phase confines traffic to a few blocks so that such damage is touched again within a handful of cycles.

// File: rtl/dir_pkg.sv
`timescale 1ns/1ps
package dir_pkg;
    typedef enum logic [2:0] {
        ST_UNOWNED  = 3'd0,
        ST_SHARED   = 3'd1,
        ST_EXCL     = 3'd2,
        ST_POISONED = 3'd3,
        ST_PEND_WB  = 3'd4,
        ST_PEND_ACK = 3'd5
    } dir_state_e;

    localparam logic [2:0] OP_READ     = 3'd0;
    localparam logic [2:0] OP_WRITE    = 3'd1;
    localparam logic [2:0] OP_WB       = 3'd2;
    localparam logic [2:0] OP_ACK      = 3'd3;
    localparam logic [2:0] OP_POISON   = 3'd4;
    localparam logic [2:0] OP_UNPOISON = 3'd5;

    typedef enum logic [2:0] {
        RS_GRANT_SHR  = 3'd0,
        RS_GRANT_EXCL = 3'd1,
        RS_NACK       = 3'd2,
        RS_BUSERR     = 3'd3,
        RS_DONE       = 3'd4,
        RS_ACCEPT     = 3'd5
    } dir_rsp_e;
endpackage

// File: rtl/dir_store.sv
`timescale 1ns/1ps
module dir_store
    import dir_pkg::*;
#(
    parameter int NBLK   = 16,
    parameter int NNODE  = 4,
    parameter int BLK_W  = $clog2(NBLK),
    parameter int NODE_W = $clog2(NNODE)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BLK_W-1:0]  rd_blk,
    output dir_state_e        rd_state,
    output logic [NNODE-1:0]  rd_sharers,
    output logic [NODE_W-1:0] rd_owner,
    input  logic              wr_en,
    input  logic [BLK_W-1:0]  wr_blk,
    input  dir_state_e        wr_state,
    input  logic [NNODE-1:0]  wr_sharers,
    input  logic [NODE_W-1:0] wr_owner
);
    dir_state_e        state_q   [NBLK];
    logic [NNODE-1:0]  sharers_q [NBLK];
    logic [NODE_W-1:0] owner_q   [NBLK];

    for (genvar i = 0; i < NBLK; i++) begin : g_entry
        dir_state_e        state_d;
        logic [NNODE-1:0]  sharers_d;
        logic [NODE_W-1:0] owner_d;
        logic              hit;

        always_comb begin
            hit       = wr_en && (wr_blk == BLK_W'(i));
            state_d   = hit ? wr_state   : state_q[i];
            sharers_d = hit ? wr_sharers : sharers_q[i];
            owner_d   = hit ? wr_owner   : owner_q[i];
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                state_q[i]   <= ST_UNOWNED;
                sharers_q[i] <= '0;
                owner_q[i]   <= '0;
            end else begin
                state_q[i]   <= state_d;
                sharers_q[i] <= sharers_d;
                owner_q[i]   <= owner_d;
            end
        end

        // a pending-acknowledge entry always waits on at least one sharer
        assert_pend_list_nonempty_R9: assert property (@(posedge clk) disable iff (!rst_n)
            state_q[i] == ST_PEND_ACK |-> sharers_q[i] != '0);
        // poisoned entries hold nobody
        assert_poisoned_empty_R12: assert property (@(posedge clk) disable iff (!rst_n)
            state_q[i] == ST_POISONED |-> sharers_q[i] == '0);
    end

    always_comb begin
        rd_state   = state_q[rd_blk];
        rd_sharers = sharers_q[rd_blk];
        rd_owner   = owner_q[rd_blk];
    end
endmodule

// File: rtl/dir_proto.sv
`timescale 1ns/1ps
module dir_proto
    import dir_pkg::*;
#(
    parameter int NNODE  = 4,
    parameter int NODE_W = $clog2(NNODE)
) (
    input  logic [2:0]        op,
    input  logic [NODE_W-1:0] node,
    input  dir_state_e        cur_state,
    input  logic [NNODE-1:0]  cur_sharers,
    input  logic [NODE_W-1:0] cur_owner,
    output logic              wr_en,
    output dir_state_e        nx_state,
    output logic [NNODE-1:0]  nx_sharers,
    output logic [NODE_W-1:0] nx_owner,
    output dir_rsp_e          rsp_code,
    output logic              inv_valid,
    output logic [NNODE-1:0]  inv_mask,
    output logic              intv_valid,
    output logic [NODE_W-1:0] intv_node,
    output logic              poison_done
);
    logic [NNODE-1:0] node_bit;
    logic [NNODE-1:0] owner_bit;
    logic [NNODE-1:0] others;
    logic [NNODE-1:0] remain;
    logic             is_owner;

    always_comb begin
        node_bit  = NNODE'(1) << node;
        owner_bit = NNODE'(1) << cur_owner;
        others    = cur_sharers & ~node_bit;
        remain    = cur_sharers & ~node_bit;
        is_owner  = (node == cur_owner);

        wr_en       = 1'b0;
        nx_state    = cur_state;
        nx_sharers  = cur_sharers;
        nx_owner    = cur_owner;
        rsp_code    = RS_NACK;
        inv_valid   = 1'b0;
        inv_mask    = '0;
        intv_valid  = 1'b0;
        intv_node   = '0;
        poison_done = 1'b0;

        if (op == OP_ACK) begin
            rsp_code = RS_DONE;
            if (cur_state == ST_PEND_ACK && (cur_sharers & node_bit) != '0) begin
                wr_en      = 1'b1;
                nx_sharers = remain;
                if (remain == '0) begin
                    nx_state    = ST_POISONED;
                    poison_done = 1'b1;
                end
            end
        end else begin
            case (cur_state)
                ST_UNOWNED: begin
                    if (op == OP_READ || op == OP_WRITE) begin
                        wr_en      = 1'b1;
                        nx_state   = ST_EXCL;
                        nx_owner   = node;
                        nx_sharers = '0;
                        rsp_code   = RS_GRANT_EXCL;
                    end else if (op == OP_POISON) begin
                        wr_en       = 1'b1;
                        nx_state    = ST_POISONED;
                        rsp_code    = RS_DONE;
                        poison_done = 1'b1;
                    end
                end
                ST_SHARED: begin
                    if (op == OP_READ) begin
                        wr_en      = 1'b1;
                        nx_sharers = cur_sharers | node_bit;
                        rsp_code   = RS_GRANT_SHR;
                    end else if (op == OP_WRITE) begin
                        wr_en      = 1'b1;
                        nx_state   = ST_EXCL;
                        nx_owner   = node;
                        nx_sharers = '0;
                        inv_valid  = (others != '0);
                        inv_mask   = others;
                        rsp_code   = RS_GRANT_EXCL;
                    end else if (op == OP_POISON) begin
                        wr_en     = 1'b1;
                        nx_state  = ST_PEND_ACK;
                        inv_valid = 1'b1;
                        inv_mask  = cur_sharers;
                        rsp_code  = RS_ACCEPT;
                    end
                end
                ST_EXCL: begin
                    if (op == OP_READ || op == OP_WRITE) begin
                        rsp_code = RS_GRANT_EXCL;
                        if (!is_owner) begin
                            wr_en      = 1'b1;
                            intv_valid = 1'b1;
                            intv_node  = cur_owner;
                            if (op == OP_READ) begin
                                nx_state   = ST_SHARED;
                                nx_sharers = node_bit | owner_bit;
                                nx_owner   = '0;
                                rsp_code   = RS_GRANT_SHR;
                            end else begin
                                nx_owner = node;
                            end
                        end
                    end else if (op == OP_WB && is_owner) begin
                        wr_en    = 1'b1;
                        nx_state = ST_UNOWNED;
                        nx_owner = '0;
                        rsp_code = RS_DONE;
                    end else if (op == OP_POISON) begin
                        wr_en      = 1'b1;
                        nx_state   = ST_PEND_WB;
                        intv_valid = 1'b1;
                        intv_node  = cur_owner;
                        rsp_code   = RS_ACCEPT;
                    end
                end
                ST_POISONED: begin
                    if (op == OP_READ || op == OP_WRITE) begin
                        rsp_code = RS_BUSERR;
                    end else if (op == OP_POISON) begin
                        rsp_code = RS_DONE;
                    end else if (op == OP_UNPOISON) begin
                        wr_en      = 1'b1;
                        nx_state   = ST_UNOWNED;
                        nx_sharers = '0;
                        nx_owner   = '0;
                        rsp_code   = RS_DONE;
                    end
                end
                ST_PEND_WB: begin
                    if (op == OP_WB && is_owner) begin
                        wr_en       = 1'b1;
                        nx_state    = ST_POISONED;
                        nx_owner    = '0;
                        nx_sharers  = '0;
                        rsp_code    = RS_DONE;
                        poison_done = 1'b1;
                    end
                end
                default: rsp_code = RS_NACK;
            endcase
        end
    end
endmodule

// File: rtl/dir_poison_ctrl.sv
`timescale 1ns/1ps
module dir_poison_ctrl
    import dir_pkg::*;
#(
    parameter int NBLK   = 16,
    parameter int NNODE  = 4,
    parameter int BLK_W  = $clog2(NBLK),
    parameter int NODE_W = $clog2(NNODE)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_op,
    input  logic [NODE_W-1:0] req_node,
    input  logic [BLK_W-1:0]  req_blk,
    output logic              rsp_valid,
    output logic [NODE_W-1:0] rsp_node,
    output logic [2:0]        rsp_code,
    output logic              inv_valid,
    output logic [NNODE-1:0]  inv_mask,
    output logic              intv_valid,
    output logic [NODE_W-1:0] intv_node,
    output logic              poison_done,
    output logic [BLK_W-1:0]  poison_blk
);
    typedef struct packed {
        logic              rsp_valid;
        logic [NODE_W-1:0] rsp_node;
        logic [2:0]        rsp_code;
        logic              inv_valid;
        logic [NNODE-1:0]  inv_mask;
        logic              intv_valid;
        logic [NODE_W-1:0] intv_node;
        logic              poison_done;
        logic [BLK_W-1:0]  poison_blk;
    } out_t;

    out_t out_d, out_q;

    dir_state_e        rd_state, nx_state;
    logic [NNODE-1:0]  rd_sharers, nx_sharers, p_inv_mask;
    logic [NODE_W-1:0] rd_owner, nx_owner, p_intv_node;
    logic              p_wr_en, p_inv_valid, p_intv_valid, p_done;
    dir_rsp_e          p_rsp;

    dir_store #(.NBLK(NBLK), .NNODE(NNODE), .BLK_W(BLK_W), .NODE_W(NODE_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_blk     (req_blk),
        .rd_state   (rd_state),
        .rd_sharers (rd_sharers),
        .rd_owner   (rd_owner),
        .wr_en      (p_wr_en && req_valid),
        .wr_blk     (req_blk),
        .wr_state   (nx_state),
        .wr_sharers (nx_sharers),
        .wr_owner   (nx_owner)
    );

    dir_proto #(.NNODE(NNODE), .NODE_W(NODE_W)) u_proto (
        .op          (req_op),
        .node        (req_node),
        .cur_state   (rd_state),
        .cur_sharers (rd_sharers),
        .cur_owner   (rd_owner),
        .wr_en       (p_wr_en),
        .nx_state    (nx_state),
        .nx_sharers  (nx_sharers),
        .nx_owner    (nx_owner),
        .rsp_code    (p_rsp),
        .inv_valid   (p_inv_valid),
        .inv_mask    (p_inv_mask),
        .intv_valid  (p_intv_valid),
        .intv_node   (p_intv_node),
        .poison_done (p_done)
    );

    always_comb begin
        out_d = '0;
        if (req_valid) begin
            out_d.rsp_valid   = 1'b1;
            out_d.rsp_node    = req_node;
            out_d.rsp_code    = p_rsp;
            out_d.inv_valid   = p_inv_valid;
            out_d.inv_mask    = p_inv_mask;
            out_d.intv_valid  = p_intv_valid;
            out_d.intv_node   = p_intv_node;
            out_d.poison_done = p_done;
            out_d.poison_blk  = p_done ? req_blk : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign rsp_valid   = out_q.rsp_valid;
    assign rsp_node    = out_q.rsp_node;
    assign rsp_code    = out_q.rsp_code;
    assign inv_valid   = out_q.inv_valid;
    assign inv_mask    = out_q.inv_mask;
    assign intv_valid  = out_q.intv_valid;
    assign intv_node   = out_q.intv_node;
    assign poison_done = out_q.poison_done;
    assign poison_blk  = out_q.poison_blk;

    assert_one_rsp_R13: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid && rsp_node == $past(req_node));
    assert_no_rsp_idle_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    assert_buserr_on_poisoned_R11: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && rd_state == ST_POISONED && (req_op == OP_READ || req_op == OP_WRITE)
        |=> rsp_code == RS_BUSERR);
    assert_pending_nack_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && (rd_state == ST_PEND_WB || rd_state == ST_PEND_ACK)
        && (req_op == OP_READ || req_op == OP_WRITE || req_op == OP_POISON || req_op == OP_UNPOISON)
        |=> rsp_code == RS_NACK && !poison_done);
    assert_done_has_rsp_R8: assert property (@(posedge clk) disable iff (!rst_n)
        poison_done |-> rsp_valid && rsp_code == RS_DONE);
    assert_msg_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(inv_valid && intv_valid));
endmodule

// File: tb/dir_poison_ctrl_tb.sv
`timescale 1ns/1ps
module dir_poison_ctrl_tb;
    localparam int NBLK = 16;
    localparam int NNODE = 4;
    localparam int BW = 4;
    localparam int NW = 2;

    // model state codes
    localparam int UN = 0, SH = 1, EX = 2, PO = 3, PW = 4, PA = 5;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n, req_valid;
    logic [2:0] req_op;
    logic [NW-1:0] req_node;
    logic [BW-1:0] req_blk;
    logic rsp_valid, inv_valid, intv_valid, poison_done;
    logic [NW-1:0] rsp_node, intv_node;
    logic [2:0] rsp_code;
    logic [NNODE-1:0] inv_mask;
    logic [BW-1:0] poison_blk;

    dir_poison_ctrl #(.NBLK(NBLK), .NNODE(NNODE)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_node(req_node), .req_blk(req_blk), .rsp_valid(rsp_valid),
        .rsp_node(rsp_node), .rsp_code(rsp_code), .inv_valid(inv_valid),
        .inv_mask(inv_mask), .intv_valid(intv_valid), .intv_node(intv_node),
        .poison_done(poison_done), .poison_blk(poison_blk)
    );

    int m_st [NBLK];
    int m_sh [NBLK];
    int m_ow [NBLK];

    int n_cmp = 0, n_bad = 0;
    bit finished = 0;
    string tag;
    int e_rv, e_rn, e_rc, e_iv, e_im, e_tv, e_tn, e_pd, e_pb;

    task automatic clear_exp();
        e_rv = 0; e_rn = 0; e_rc = 0; e_iv = 0; e_im = 0;
        e_tv = 0; e_tn = 0; e_pd = 0; e_pb = 0;
    endtask

    task automatic compare();
        n_cmp++;
        if (rsp_valid !== e_rv[0] || rsp_node !== NW'(e_rn) || rsp_code !== 3'(e_rc) ||
            inv_valid !== e_iv[0] || inv_mask !== NNODE'(e_im) || intv_valid !== e_tv[0] ||
            intv_node !== NW'(e_tn) || poison_done !== e_pd[0] || poison_blk !== BW'(e_pb)) begin
            n_bad++;
            $display("FAIL %s: got rv=%0d rn=%0d rc=%0d iv=%0d im=%0h tv=%0d tn=%0d pd=%0d pb=%0d exp rv=%0d rn=%0d rc=%0d iv=%0d im=%0h tv=%0d tn=%0d pd=%0d pb=%0d",
                tag, rsp_valid, rsp_node, rsp_code, inv_valid, inv_mask, intv_valid,
                intv_node, poison_done, poison_blk, e_rv, e_rn, e_rc, e_iv, e_im,
                e_tv, e_tn, e_pd, e_pb);
        end
    endtask

    // behavioural reference directory: rsp 0 shr,1 excl,2 nack,3 buserr,4 done,5 accept
    task automatic model(bit v, int op, int nd, int b);
        int bit_n, rem;
        clear_exp();
        if (!v) begin tag = "R13 idle"; return; end
        e_rv = 1; e_rn = nd; e_rc = 2;
        bit_n = 1 << nd;
        if (op == 3) begin
            e_rc = 4; tag = "R9 ack";
            if (m_st[b] == PA && (m_sh[b] & bit_n) != 0) begin
                rem = m_sh[b] & ~bit_n;
                m_sh[b] = rem;
                if (rem == 0) begin
                    m_st[b] = PO; e_pd = 1; e_pb = b; tag = "R9 last ack";
                end
            end
            return;
        end
        if (op > 5) begin tag = "R12 bad op"; return; end
        case (m_st[b])
            UN: begin
                if (op <= 1) begin
                    tag = (op == 0) ? "R2 read unowned" : "R4 write unowned";
                    m_st[b] = EX; m_ow[b] = nd; m_sh[b] = 0; e_rc = 1;
                end else if (op == 4) begin
                    tag = "R7 poison unowned"; m_st[b] = PO; e_rc = 4; e_pd = 1; e_pb = b;
                end else tag = (op == 2) ? "R6 wb unowned" : "R12 unpoison unowned";
            end
            SH: begin
                if (op == 0) begin
                    tag = "R3 read shared"; m_sh[b] = m_sh[b] | bit_n; e_rc = 0;
                end else if (op == 1) begin
                    tag = "R4 write shared";
                    e_im = m_sh[b] & ~bit_n; e_iv = (e_im != 0);
                    m_st[b] = EX; m_ow[b] = nd; m_sh[b] = 0; e_rc = 1;
                end else if (op == 4) begin
                    tag = "R9 poison shared";
                    e_iv = 1; e_im = m_sh[b]; m_st[b] = PA; e_rc = 5;
                end else tag = (op == 2) ? "R6 wb shared" : "R12 unpoison shared";
            end
            EX: begin
                if (op <= 1) begin
                    if (nd == m_ow[b]) begin
                        tag = "R5 owner rerequest"; e_rc = 1;
                    end else begin
                        e_tv = 1; e_tn = m_ow[b];
                        if (op == 0) begin
                            tag = "R3 read excl";
                            m_sh[b] = bit_n | (1 << m_ow[b]); m_ow[b] = 0; m_st[b] = SH; e_rc = 0;
                        end else begin
                            tag = "R4 write excl"; m_ow[b] = nd; e_rc = 1;
                        end
                    end
                end else if (op == 2) begin
                    if (nd == m_ow[b]) begin
                        tag = "R6 wb owner"; m_st[b] = UN; m_ow[b] = 0; e_rc = 4;
                    end else tag = "R6 wb nonowner";
                end else if (op == 4) begin
                    tag = "R8 poison excl"; e_tv = 1; e_tn = m_ow[b]; m_st[b] = PW; e_rc = 5;
                end else tag = "R12 unpoison excl";
            end
            PO: begin
                if (op <= 1) begin tag = "R11 access poisoned"; e_rc = 3; end
                else if (op == 4) begin tag = "R7 poison poisoned"; e_rc = 4; end
                else if (op == 5) begin
                    tag = "R12 unpoison"; m_st[b] = UN; m_sh[b] = 0; m_ow[b] = 0; e_rc = 4;
                end else tag = "R6 wb poisoned";
            end
            PW: begin
                if (op == 2 && nd == m_ow[b]) begin
                    tag = "R8 wb completes poison";
                    m_st[b] = PO; m_ow[b] = 0; m_sh[b] = 0; e_rc = 4; e_pd = 1; e_pb = b;
                end else tag = "R10 pending wb";
            end
            default: tag = "R10 pending ack";
        endcase
    endtask

    task automatic step(bit v, int op, int nd, int b);
        req_valid = v; req_op = 3'(op); req_node = NW'(nd); req_blk = BW'(b);
        model(v, op, nd, b);
        @(negedge clk);
        compare();
    endtask

    initial begin
        #1000000;
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: got hung run, exp completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NBLK; i++) begin m_st[i] = UN; m_sh[i] = 0; m_ow[i] = 0; end
        rst_n = 1'b0; req_valid = 1'b0; req_op = '0; req_node = '0; req_blk = '0;
        repeat (3) @(negedge clk);
        clear_exp(); tag = "R1 reset state"; compare();
        rst_n = 1'b1;
        step(0, 0, 0, 0);
        // R1 / R2: first read of a fresh block
        step(1, 0, 2, 5);
        // R5: owner re-reads and re-writes
        step(1, 0, 2, 5);
        step(1, 1, 2, 5);
        // R3: another reader downgrades owner
        step(1, 0, 1, 5);
        step(1, 0, 3, 5);
        // R4: write on shared invalidates others
        step(1, 1, 1, 5);
        // R4: write on exclusive of other
        step(1, 1, 0, 5);
        // R6: writeback from non-owner then owner
        step(1, 2, 3, 5);
        step(1, 2, 0, 5);
        // R7: poison unowned, re-poison, R11 access, R12 unpoison
        step(1, 4, 0, 5);
        step(1, 4, 1, 5);
        step(1, 0, 2, 5);
        step(1, 1, 3, 5);
        step(1, 5, 0, 5);
        step(1, 5, 0, 5);
        step(1, 0, 1, 5);
        // R8: poison exclusive, pending NACKs, wrong writer, then owner wb
        step(1, 4, 0, 5);
        step(1, 0, 2, 5);
        step(1, 1, 2, 5);
        step(1, 4, 0, 5);
        step(1, 5, 0, 5);
        step(1, 2, 3, 5);
        step(1, 2, 1, 5);
        step(1, 0, 1, 5);
        step(1, 5, 0, 5);
        // R9: poison shared by three nodes, acks including duplicates
        step(1, 0, 0, 9);
        step(1, 0, 1, 9);
        step(1, 0, 3, 9);
        step(1, 4, 2, 9);
        step(1, 0, 2, 9);
        step(1, 3, 2, 9);
        step(1, 3, 0, 9);
        step(1, 3, 0, 9);
        step(1, 3, 1, 9);
        step(1, 3, 3, 9);
        step(1, 1, 0, 9);
        // R12: illegal op codes
        step(1, 6, 1, 9);
        step(1, 7, 2, 3);
        step(0, 0, 0, 0);
        // random traffic on a few blocks
        for (int k = 0; k < 4000; k++) begin
            step(($urandom_range(0, 7) != 0), $urandom_range(0, 7),
                 $urandom_range(0, NNODE - 1), $urandom_range(0, 3));
        end
        step(0, 0, 0, 0);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule